// File: doc/BRIEF.md
# Queue-Processor Instruction Decoder with Address-Extension Prefix

This block sits in the decode stage of a queue processor whose instructions are all 16 bits wide. It classifies each instruction and picks out the base-register select. It forms a 16-bit offset, immediate or displacement. For control transfers it evaluates the branch condition against the flags and computes the redirect target.

A one-byte prefix instruction can come before a memory or control instruction. The decoder holds the prefix payload. It then uses that payload as the upper byte of the next instruction's 8-bit field, which widens that field to 16 bits. Only the single instruction after the prefix consumes the held payload. That instruction clears it whether or not it uses it.

All decode outputs are combinational from the current instruction and the held prefix state. The only storage is the prefix payload and its pending flag, and these change on a clock edge where `instr_valid` is high. A jump or call reads its base from `reg_val`, which the surrounding pipeline drives with the register chosen by `base_sel`.

Top module: `qpd_decoder`

## Requirements
- R1: During and after reset, `pfx_pending` is 0, and `redirect` is 0 while `instr_valid` is 0.
- R2: An instruction whose bits 15:8 equal 0x04 is a prefix. `dec_cls` is 6, `redirect` stays 0, and after the clock edge `pfx_pending` is 1 and the payload is bits 7:0.
- R3: Bits 15:10 equal to 2 give a load (`dec_cls` 1) and equal to 3 give a store (`dec_cls` 2). `base_sel` is bits 9:8. With no pending prefix, `eff_imm` is bits 7:0 zero-extended.
- R4: A load or store decoded while a prefix is pending has `eff_imm` = {payload, bits 7:0}.
- R5: Any valid instruction that is not a prefix clears `pfx_pending` at its clock edge, including instructions that ignore the payload. A following load then sees a zero upper byte.
- R6: Cycles with `instr_valid` low leave `pfx_pending` and the payload unchanged.
- R7: When two prefixes come back to back, the later payload replaces the earlier one, and the prefix stays pending.
- R8: Bits 15:11 equal to 00110 give a branch (`dec_cls` 3), and `cond_code` is bits 10:8. With no pending prefix, the displacement `eff_imm` is bits 7:0 sign-extended, and `target_pc` = `pc` + 2·displacement, taken modulo 2^PC_W.
- R9: A branch, jump or call decoded while a prefix is pending uses the displacement {payload, bits 7:0}, read as a signed 16-bit value.
- R10: Condition codes are 0 always, 1 eq (Z), 2 ne (!Z), 3 lt (N≠V), 4 gt (!Z and N=V), 5 le (Z or N≠V) and 6 ge (N=V). A valid branch asserts `redirect` exactly when its condition holds.
- R11: Bits 15:10 equal to 4 give a jump (`dec_cls` 4) and equal to 5 give a call (`dec_cls` 5). `base_sel` is bits 9:8, `target_pc` = `reg_val` + 2·displacement, and `redirect` is 1.
- R12: Condition code 7 in a branch, and bits 15:10 equal to 1 with bits 9:8 nonzero, give illegal (`dec_cls` 7). Every other pattern gives other (`dec_cls` 0) with `eff_imm` = bits 7:0 zero-extended. Neither class redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | The instruction on `instr` is live this cycle |
| instr | input | 16 | Instruction word |
| pc | input | PC_W | Address of the current instruction |
| reg_val | input | PC_W | Value of the register selected by `base_sel` (jump/call base) |
| flag_z | input | 1 | Zero flag of the last signed compare |
| flag_n | input | 1 | Negative flag of the last signed compare |
| flag_v | input | 1 | Overflow flag of the last signed compare |
| dec_cls | output | 3 | Instruction class code |
| base_sel | output | 2 | Base register select (memory, jump, call; else 0) |
| eff_imm | output | 16 | Effective offset, immediate or displacement |
| cond_code | output | 3 | Branch condition (0 for non-branches) |
| redirect | output | 1 | Control flow leaves the sequential path |
| target_pc | output | PC_W | Redirect target address |
| pfx_pending | output | 1 | A prefix payload is waiting for the next instruction |

## Verification
The assertions assume that `instr_valid` marks each instruction for exactly one clock. They also assume that `flag_z`, `flag_n` and `flag_v` and `reg_val` are settled before the edge, and that `instr` has no unknown bits while `instr_valid` is high. The stimulus drives every input on the falling edge, keeps each instruction live for one cycle only, and holds the flags and `reg_val` steady while a branch or jump is presented. Idle cycles in the sequences deliberately put junk on `instr` with `instr_valid` low, so the checks show that the prefix state ignores it.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

   typedef enum logic [2:0] {
      CLS_OTHER   = 3'd0,
      CLS_LOAD    = 3'd1,
      CLS_STORE   = 3'd2,
      CLS_BRANCH  = 3'd3,
      CLS_JUMP    = 3'd4,
      CLS_CALL    = 3'd5,
      CLS_PREFIX  = 3'd6,
      CLS_ILLEGAL = 3'd7
   } qpd_cls_e;

   typedef enum logic [2:0] {
      CND_ALWAYS = 3'd0,
      CND_EQ     = 3'd1,
      CND_NE     = 3'd2,
      CND_LT     = 3'd3,
      CND_GT     = 3'd4,
      CND_LE     = 3'd5,
      CND_GE     = 3'd6,
      CND_RSVD   = 3'd7
   } qpd_cond_e;

   localparam int unsigned INSN_W  = 16;
   localparam int unsigned FIELD_W = 8;

   localparam logic [7:0] PFX_BYTE  = 8'h04;
   localparam logic [5:0] OP_PFXGRP = 6'h01;
   localparam logic [5:0] OP_LOAD   = 6'h02;
   localparam logic [5:0] OP_STORE  = 6'h03;
   localparam logic [5:0] OP_JUMP   = 6'h04;
   localparam logic [5:0] OP_CALL   = 6'h05;
   localparam logic [4:0] OP_BRGRP  = 5'b00110;

endpackage

// File: rtl/qpd_opdecode.sv
module qpd_opdecode
   import qpd_pkg::*;
#(
   parameter bit PREFIX_EN = 1'b1
) (
   input  logic [7:0] hi_byte,
   output qpd_cls_e   cls,
   output qpd_cond_e  cond
);

   always_comb begin
      cls  = CLS_OTHER;
      cond = CND_ALWAYS;
      if (hi_byte == PFX_BYTE) begin
         cls = PREFIX_EN ? CLS_PREFIX : CLS_OTHER;
      end else if (hi_byte[7:3] == OP_BRGRP) begin
         if (qpd_cond_e'(hi_byte[2:0]) == CND_RSVD) begin
            cls = CLS_ILLEGAL;
         end else begin
            cls  = CLS_BRANCH;
            cond = qpd_cond_e'(hi_byte[2:0]);
         end
      end else begin
         case (hi_byte[7:2])
            OP_PFXGRP: cls = CLS_ILLEGAL;
            OP_LOAD:   cls = CLS_LOAD;
            OP_STORE:  cls = CLS_STORE;
            OP_JUMP:   cls = CLS_JUMP;
            OP_CALL:   cls = CLS_CALL;
            default:   cls = CLS_OTHER;
         endcase
      end
   end

endmodule

// File: rtl/qpd_prefix_state.sv
module qpd_prefix_state
   import qpd_pkg::*;
#(
   parameter bit PREFIX_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic               is_pfx,
   input  logic [FIELD_W-1:0] payload,
   output logic               pending,
   output logic [FIELD_W-1:0] hi_byte
);

   generate
      if (PREFIX_EN) begin : g_latch
         logic               pend_q;
         logic [FIELD_W-1:0] hi_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
               hi_q   <= '0;
            end else if (step) begin
               pend_q <= is_pfx;
               if (is_pfx) begin
                  hi_q <= payload;
               end
            end
         end

         assign pending = pend_q;
         assign hi_byte = hi_q;
      end else begin : g_none
         logic unused_pfx;
         assign unused_pfx = ^{clk, rst_n, step, is_pfx, payload};
         assign pending    = 1'b0;
         assign hi_byte    = '0;
      end
   endgenerate

endmodule

// File: rtl/qpd_imm_form.sv
module qpd_imm_form
   import qpd_pkg::*;
(
   input  qpd_cls_e             cls,
   input  logic [FIELD_W-1:0]   lo_byte,
   input  logic                 pending,
   input  logic [FIELD_W-1:0]   hi_byte,
   output logic [INSN_W-1:0]    imm
);

   logic [FIELD_W-1:0] upper_mem;
   logic [FIELD_W-1:0] upper_ctl;

   assign upper_mem = pending ? hi_byte : '0;
   assign upper_ctl = pending ? hi_byte : {FIELD_W{lo_byte[FIELD_W-1]}};

   always_comb begin
      case (cls)
         CLS_LOAD, CLS_STORE:          imm = {upper_mem, lo_byte};
         CLS_BRANCH, CLS_JUMP, CLS_CALL: imm = {upper_ctl, lo_byte};
         default:                      imm = {{FIELD_W{1'b0}}, lo_byte};
      endcase
   end

endmodule

// File: rtl/qpd_cond_eval.sv
module qpd_cond_eval
   import qpd_pkg::*;
(
   input  qpd_cond_e cond,
   input  logic      z,
   input  logic      n,
   input  logic      v,
   output logic      holds
);

   logic less;
   assign less = n ^ v;

   always_comb begin
      case (cond)
         CND_ALWAYS: holds = 1'b1;
         CND_EQ:     holds = z;
         CND_NE:     holds = !z;
         CND_LT:     holds = less;
         CND_GT:     holds = !z && !less;
         CND_LE:     holds = z || less;
         CND_GE:     holds = !less;
         default:    holds = 1'b0;
      endcase
   end

endmodule

// File: rtl/qpd_target_calc.sv
module qpd_target_calc
   import qpd_pkg::*;
#(
   parameter int unsigned PC_W = 16
) (
   input  logic              use_reg,
   input  logic [PC_W-1:0]   pc,
   input  logic [PC_W-1:0]   reg_val,
   input  logic [INSN_W-1:0] disp,
   output logic [PC_W-1:0]   target
);

   localparam int unsigned EXT_W = PC_W - INSN_W;

   logic [PC_W-1:0] disp_ext;
   logic [PC_W-1:0] base;

   generate
      if (EXT_W == 0) begin : g_same
         assign disp_ext = disp;
      end else begin : g_wide
         assign disp_ext = {{EXT_W{disp[INSN_W-1]}}, disp};
      end
   endgenerate

   assign base   = use_reg ? reg_val : pc;
   assign target = base + (disp_ext << 1);

endmodule

// File: rtl/qpd_decoder.sv
module qpd_decoder
   import qpd_pkg::*;
#(
   parameter int unsigned PC_W      = 16,
   parameter bit          PREFIX_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic [15:0]     instr,
   input  logic [PC_W-1:0] pc,
   input  logic [PC_W-1:0] reg_val,
   input  logic            flag_z,
   input  logic            flag_n,
   input  logic            flag_v,
   output logic [2:0]      dec_cls,
   output logic [1:0]      base_sel,
   output logic [15:0]     eff_imm,
   output logic [2:0]      cond_code,
   output logic            redirect,
   output logic [PC_W-1:0] target_pc,
   output logic            pfx_pending
);

   generate
      if (PC_W < INSN_W || PC_W > 32) begin : g_bad_pcw
         $error("qpd_decoder: PC_W must lie in 16..32");
      end
   endgenerate

   qpd_cls_e           cls;
   qpd_cond_e          cond;
   logic               cond_ok;
   logic               pend;
   logic [FIELD_W-1:0] pfx_hi;
   logic [INSN_W-1:0]  imm;
   logic               is_pfx;
   logic               uses_reg;

   qpd_opdecode #(.PREFIX_EN(PREFIX_EN)) u_opdec (
      .hi_byte (instr[15:8]),
      .cls     (cls),
      .cond    (cond)
   );

   assign is_pfx = (cls == CLS_PREFIX);

   qpd_prefix_state #(.PREFIX_EN(PREFIX_EN)) u_pfx (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (instr_valid),
      .is_pfx  (is_pfx),
      .payload (instr[7:0]),
      .pending (pend),
      .hi_byte (pfx_hi)
   );

   qpd_imm_form u_imm (
      .cls     (cls),
      .lo_byte (instr[7:0]),
      .pending (pend),
      .hi_byte (pfx_hi),
      .imm     (imm)
   );

   qpd_cond_eval u_cond (
      .cond  (cond),
      .z     (flag_z),
      .n     (flag_n),
      .v     (flag_v),
      .holds (cond_ok)
   );

   assign uses_reg = (cls == CLS_JUMP) || (cls == CLS_CALL);

   qpd_target_calc #(.PC_W(PC_W)) u_tgt (
      .use_reg (uses_reg),
      .pc      (pc),
      .reg_val (reg_val),
      .disp    (imm),
      .target  (target_pc)
   );

   always_comb begin
      case (cls)
         CLS_LOAD, CLS_STORE, CLS_JUMP, CLS_CALL: base_sel = instr[9:8];
         default:                                 base_sel = 2'd0;
      endcase
   end

   assign dec_cls     = cls;
   assign cond_code   = cond;
   assign eff_imm     = imm;
   assign pfx_pending = pend;
   assign redirect    = instr_valid &&
                        (((cls == CLS_BRANCH) && cond_ok) || uses_reg);

endmodule

// File: rtl/qpd_checker.sv
module qpd_checker #(
   parameter bit PREFIX_EN = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        instr_valid,
   input logic [15:0] instr,
   input logic [2:0]  dec_cls,
   input logic [15:0] eff_imm,
   input logic        redirect,
   input logic        pfx_pending
);

   logic is_pfx_word;
   logic is_mem;
   assign is_pfx_word = (instr[15:8] == 8'h04);
   assign is_mem      = (dec_cls == 3'd1) || (dec_cls == 3'd2);

   AST_RST_CLEAR: assert property (@(posedge clk)
      !rst_n |=> !pfx_pending); // R1

   AST_PFX_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (PREFIX_EN && instr_valid && is_pfx_word) |=> pfx_pending); // R2

   AST_PFX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_cls == 3'd6) |-> !redirect); // R2

   AST_PFX_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !is_pfx_word) |=> !pfx_pending); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> $stable(pfx_pending)); // R6

   AST_MEM_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && is_mem && !pfx_pending) |-> (eff_imm[15:8] == 8'h00)); // R3

   AST_MEM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && is_mem) |-> (eff_imm[7:0] == instr[7:0])); // R4

   AST_REDIR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (instr_valid && (dec_cls >= 3'd3) && (dec_cls <= 3'd5))); // R11

endmodule

bind qpd_decoder qpd_checker #(.PREFIX_EN(PREFIX_EN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr       (instr),
   .dec_cls     (dec_cls),
   .eff_imm     (eff_imm),
   .redirect    (redirect),
   .pfx_pending (pfx_pending)
);

// File: tb/qpd_decoder_test.sv
module qpd_decoder_test;

   localparam int CLK_PERIOD = 10;
   localparam int PC_W       = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_valid = 1'b0;
   logic [15:0]     instr = 16'h0000;
   logic [PC_W-1:0] pc = '0;
   logic [PC_W-1:0] reg_val = '0;
   logic            flag_z = 1'b0;
   logic            flag_n = 1'b0;
   logic            flag_v = 1'b0;
   logic [2:0]      dec_cls;
   logic [1:0]      base_sel;
   logic [15:0]     eff_imm;
   logic [2:0]      cond_code;
   logic            redirect;
   logic [PC_W-1:0] target_pc;
   logic            pfx_pending;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qpd_decoder #(.PC_W(PC_W)) uut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .pc(pc), .reg_val(reg_val), .flag_z(flag_z), .flag_n(flag_n),
      .flag_v(flag_v), .dec_cls(dec_cls), .base_sel(base_sel),
      .eff_imm(eff_imm), .cond_code(cond_code), .redirect(redirect),
      .target_pc(target_pc), .pfx_pending(pfx_pending)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One instruction slot: drive on the falling edge, settle, caller checks.
   task automatic step(input logic v, input logic [15:0] w);
      @(negedge clk);
      instr_valid = v;
      instr       = w;
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step(1'b0, 16'h04AA);
      chk("R1 pending in reset", pfx_pending, 0);
      chk("R1 redirect idle", redirect, 0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 16'h0000);
      chk("R1 pending after reset", pfx_pending, 0);
   endtask

   task automatic t_load_plain();
      step(1'b1, 16'h09F3);             // load, base 1, addr0 F3
      chk("R3 load class", dec_cls, 1);
      chk("R3 load base", base_sel, 1);
      chk("R3 load zext", eff_imm, 16'h00F3);
      step(1'b1, 16'h0E80);             // store, base 2
      chk("R3 store class", dec_cls, 2);
      chk("R3 store base", base_sel, 2);
      chk("R3 store zext", eff_imm, 16'h0080);
   endtask

   task automatic t_prefix_load();
      step(1'b1, 16'h04AB);
      chk("R2 prefix class", dec_cls, 6);
      chk("R2 prefix no redirect", redirect, 0);
      step(1'b1, 16'h09CD);
      chk("R2 pending set", pfx_pending, 1);
      chk("R4 load concat", eff_imm, 16'hABCD);
      chk("R4 load base", base_sel, 1);
      step(1'b0, 16'h0000);
      chk("R5 cleared by load", pfx_pending, 0);
   endtask

   task automatic t_oneshot();
      step(1'b1, 16'h0455);
      step(1'b1, 16'h0000);             // nop ignores payload
      chk("R12 nop other", dec_cls, 0);
      step(1'b1, 16'h0E80);
      chk("R5 pending cleared by nop", pfx_pending, 0);
      chk("R5 store no stale byte", eff_imm, 16'h0080);
      step(1'b1, 16'h0499);
      step(1'b1, 16'h3700);             // illegal also consumes
      chk("R12 illegal cond", dec_cls, 7);
      step(1'b1, 16'h0810);
      chk("R5 cleared by illegal", eff_imm, 16'h0010);
   endtask

   task automatic t_idle_hold();
      step(1'b1, 16'h0477);
      for (int i = 0; i < 3; i++) begin
         step(1'b0, 16'h3A5C);
         chk("R6 idle keeps pending", pfx_pending, 1);
      end
      step(1'b1, 16'h0801);
      chk("R6 payload kept", eff_imm, 16'h7701);
   endtask

   task automatic t_double_prefix();
      step(1'b1, 16'h0411);
      step(1'b1, 16'h0422);
      chk("R7 still pending", pfx_pending, 1);
      step(1'b1, 16'h0833);
      chk("R7 later payload wins", eff_imm, 16'h2233);
      step(1'b0, 16'h0000);
   endtask

   task automatic t_branch_plain();
      pc = 16'h1000;
      step(1'b1, 16'h30FE);
      chk("R8 branch class", dec_cls, 3);
      chk("R8 sext disp", eff_imm, 16'hFFFE);
      chk("R8 back target", target_pc, 16'h0FFC);
      chk("R8 always redirect", redirect, 1);
      pc = 16'hFFFE;
      step(1'b1, 16'h3002);
      chk("R8 wrap target", target_pc, 16'h0002);
      pc = 16'h1000;
      flag_z = 1'b0;
      step(1'b1, 16'h3104);
      chk("R8 cond field", cond_code, 1);
      chk("R10 eq not taken", redirect, 0);
   endtask

   task automatic t_branch_prefix();
      pc = 16'h1000;
      step(1'b1, 16'h0401);
      step(1'b1, 16'h3080);
      chk("R9 ext disp", eff_imm, 16'h0180);
      chk("R9 fwd target", target_pc, 16'h1300);
      step(1'b1, 16'h04FF);
      step(1'b1, 16'h3000);
      chk("R9 neg ext target", target_pc, 16'h0E00);
   endtask

   function automatic bit exp_cond(input int c, input bit z, input bit n, input bit v);
      bit lt;
      lt = (n != v);
      case (c)
         0: return 1'b1;
         1: return z;
         2: return !z;
         3: return lt;
         4: return !lt && !z;
         5: return lt || z;
         default: return !lt;
      endcase
   endfunction

   task automatic t_conditions();
      pc = 16'h0200;
      for (int c = 0; c < 7; c++) begin
         for (int f = 0; f < 8; f++) begin
            flag_z = f[0];
            flag_n = f[1];
            flag_v = f[2];
            step(1'b1, {5'b00110, 3'(c), 8'h10});
            chk("R10 cond outcome", redirect, 32'(exp_cond(c, f[0], f[1], f[2])));
         end
      end
      step(1'b0, {5'b00110, 3'd0, 8'h10});
      chk("R10 invalid no redirect", redirect, 0);
   endtask

   task automatic t_jump_call();
      reg_val = 16'h2000;
      step(1'b1, 16'h1305);
      chk("R11 jump class", dec_cls, 4);
      chk("R11 jump base", base_sel, 3);
      chk("R11 jump target", target_pc, 16'h200A);
      chk("R11 jump redirect", redirect, 1);
      reg_val = 16'h0100;
      step(1'b1, 16'h14F0);
      chk("R11 call class", dec_cls, 5);
      chk("R11 call target", target_pc, 16'h00E0);
      reg_val = 16'h4000;
      step(1'b1, 16'h0402);
      step(1'b1, 16'h1510);
      chk("R9 call ext target", target_pc, 16'h4420);
      chk("R11 call base", base_sel, 1);
   endtask

   task automatic t_other_illegal();
      step(1'b1, 16'h0500);
      chk("R12 prefix group illegal", dec_cls, 7);
      chk("R12 illegal no redirect", redirect, 0);
      step(1'b1, 16'h4412);
      chk("R12 other class", dec_cls, 0);
      chk("R12 other imm", eff_imm, 16'h0012);
      chk("R12 other no redirect", redirect, 0);
      chk("R12 other base", base_sel, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_load_plain();
      t_prefix_load();
      t_oneshot();
      t_idle_hold();
      t_double_prefix();
      t_branch_plain();
      t_branch_prefix();
      t_conditions();
      t_jump_call();
      t_other_illegal();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule